// File: doc/BRIEF.md
# Vector Reduction Unit

The unit folds the active lanes of a wide vector into one scalar. It offers four integer operations: wrapping sum, bitwise AND, bitwise OR and bitwise XOR. The vector is split into lanes of 8, 16, 32 or 64 bits. A predicate mask selects which lanes take part. A lane that is masked off contributes the identity value of the chosen operation.

Each request picks one of two accumulation orders. The sequential order folds one lane per cycle, starting at lane 0 and moving upward, so the result is built as ((a0+a1)+a2)+a3. The tree order combines neighbouring pairs in each cycle, so the result is built as (a0+a1)+(a2+a3), and it finishes in log2(lanes) cycles. The scalar result is zero-extended to 64 bits. A one-cycle done pulse marks it as valid. A busy flag tells the requester when a new start will be accepted.

Top module: `vred_top`

## Requirements
- R1: With op_i = 0 the unit computes the sum of the active lane values modulo 2^W, where W is the lane width. For example, 32 active 8-bit lanes that each hold 0xFF give 0xE0.
- R2: op_i = 1 gives the bitwise AND of the active lanes, op_i = 2 gives the bitwise OR and op_i = 3 gives the bitwise XOR.
- R3: result_o carries the reduced value in bits W-1:0, and every bit above W is zero.
- R4: Lane i takes part only when pred_i[i] is 1. A lane that is masked off contributes 0 to sum, OR and XOR, and all ones (W bits wide) to AND. Predicate bits at or above the lane count VLEN/W have no effect.
- R5: With tree_i = 0, done_o rises exactly VLEN/W clock edges after the edge that accepted start. With tree_i = 1, it rises exactly log2(VLEN/W) edges after that edge.
- R6: done_o stays high for exactly one cycle. result_o changes only in the cycle where done_o is high, and it then holds until the next completion.
- R7: While busy_o is 1, start_i and every other request input are ignored. The result and the latency of the reduction in flight stay those of the original request.
- R8: For the same vector, predicate, width and operation, the sequential order and the tree order return the same result.
- R9: esz_i selects the lane width: 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits. Lane i occupies vector bits i*W+W-1 down to i*W.
- R10: After reset, done_o and busy_o are 0 and result_o is 0. A start is accepted only on an edge where busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a reduction, sampled while idle |
| vec_i | input | VLEN | Source vector |
| pred_i | input | VLEN/8 | Lane activity mask, bit i governs lane i |
| esz_i | input | 2 | Lane width select |
| op_i | input | 2 | Operation select |
| tree_i | input | 1 | 1 selects the pairwise tree order, 0 the sequential order |
| result_o | output | 64 | Reduced scalar, zero-extended |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | A reduction is in progress |

## Verification
The bench builds the unit with VLEN = 256. This gives 32, 16, 8 and 4 lanes at the four widths. It covers every sequential latency from 4 to 32 cycles and every tree depth from 2 to 5 stages. At the 8-bit width a sum can overflow many times, which exercises the modulo wrap. At the 64-bit width there are 28 predicate bits above the last lane, so the bench can show that those bits are ignored.

// File: rtl/vred_pkg.sv
package vred_pkg;

    typedef enum logic [1:0] {
        OP_SUM = 2'd0,
        OP_AND = 2'd1,
        OP_OR  = 2'd2,
        OP_XOR = 2'd3
    } vred_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEQ  = 2'd1,
        ST_TREE = 2'd2
    } vred_state_e;

    // Mask covering the bits of one lane for a given width code.
    function automatic logic [63:0] vred_width_mask(input logic [1:0] esz);
        logic [63:0] m;
        case (esz)
            2'd0:    m = 64'h0000_0000_0000_00FF;
            2'd1:    m = 64'h0000_0000_0000_FFFF;
            2'd2:    m = 64'h0000_0000_FFFF_FFFF;
            default: m = 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
        return m;
    endfunction

    // Neutral element of each operation at the given width.
    function automatic logic [63:0] vred_identity(input vred_op_e op, input logic [1:0] esz);
        return (op == OP_AND) ? vred_width_mask(esz) : 64'd0;
    endfunction

endpackage

// File: rtl/vred_alu.sv
module vred_alu
    import vred_pkg::*;
(
    input  vred_op_e    op_i,
    input  logic [1:0]  esz_i,
    input  logic [63:0] a_i,
    input  logic [63:0] b_i,
    output logic [63:0] y_o
);
    logic [63:0] raw;

    always_comb begin
        case (op_i)
            OP_SUM:  raw = a_i + b_i;
            OP_AND:  raw = a_i & b_i;
            OP_OR:   raw = a_i | b_i;
            default: raw = a_i ^ b_i;
        endcase
        // Truncating to the lane width gives the modulo wrap of the sum.
        y_o = raw & vred_width_mask(esz_i);
    end
endmodule

// File: rtl/vred_lane_sel.sv
module vred_lane_sel
    import vred_pkg::*;
#(
    parameter int VLEN = 256,
    parameter int IDX  = 0
) (
    input  logic [VLEN-1:0] vec_i,
    input  logic            act_i,
    input  logic [1:0]      esz_i,
    input  vred_op_e        op_i,
    output logic [63:0]     elem_o
);
    localparam bit HAS16 = (IDX < VLEN / 16);
    localparam bit HAS32 = (IDX < VLEN / 32);
    localparam bit HAS64 = (IDX < VLEN / 64);

    logic [63:0] e8, e16, e32, e64;
    logic        unused_vec;

    assign unused_vec = ^vec_i;
    assign e8 = {56'd0, vec_i[IDX*8 +: 8]};

    generate
        if (HAS16) begin : g_w16
            assign e16 = {48'd0, vec_i[IDX*16 +: 16]};
        end else begin : g_n16
            assign e16 = 64'd0;
        end
        if (HAS32) begin : g_w32
            assign e32 = {32'd0, vec_i[IDX*32 +: 32]};
        end else begin : g_n32
            assign e32 = 64'd0;
        end
        if (HAS64) begin : g_w64
            assign e64 = vec_i[IDX*64 +: 64];
        end else begin : g_n64
            assign e64 = 64'd0;
        end
    endgenerate

    always_comb begin
        elem_o = vred_identity(op_i, esz_i);
        case (esz_i)
            2'd0:    if (act_i)          elem_o = e8;
            2'd1:    if (act_i && HAS16) elem_o = e16;
            2'd2:    if (act_i && HAS32) elem_o = e32;
            default: if (act_i && HAS64) elem_o = e64;
        endcase
    end
endmodule

// File: rtl/vred_top.sv
module vred_top
    import vred_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [VLEN-1:0]   vec_i,
    input  logic [VLEN/8-1:0] pred_i,
    input  logic [1:0]        esz_i,
    input  logic [1:0]        op_i,
    input  logic              tree_i,
    output logic [63:0]       result_o,
    output logic              done_o,
    output logic              busy_o
);
    localparam int MAXL = VLEN / 8;
    localparam int HALF = MAXL / 2;
    localparam int LG   = $clog2(MAXL);
    localparam int CW   = LG + 1;

    typedef struct packed {
        vred_state_e             state;
        vred_op_e                op;
        logic [1:0]              esz;
        logic                    tree;
        logic [CW-1:0]           cnt;
        logic [CW-1:0]           last;
        logic [63:0]             acc;
        logic [MAXL-1:0][63:0]   slots;
        logic [63:0]             result;
        logic                    done;
    } regs_t;

    regs_t r_d, r_q;

    logic [MAXL-1:0][63:0] lane_w;
    logic [MAXL-1:0][63:0] tree_y;
    logic [63:0]           seq_y;
    logic [63:0]           ident_q;
    vred_op_e              op_in;

    assign op_in   = vred_op_e'(op_i);
    assign ident_q = vred_identity(r_q.op, r_q.esz);

    // Lane extraction with predicate masking.
    generate
        for (genvar i = 0; i < MAXL; i++) begin : g_lane
            vred_lane_sel #(.VLEN(VLEN), .IDX(i)) u_sel (
                .vec_i  (vec_i),
                .act_i  (pred_i[i]),
                .esz_i  (esz_i),
                .op_i   (op_in),
                .elem_o (lane_w[i])
            );
        end
        // One tree stage: slot k takes the combination of slots 2k and 2k+1.
        for (genvar k = 0; k < HALF; k++) begin : g_pair
            vred_alu u_alu (
                .op_i  (r_q.op),
                .esz_i (r_q.esz),
                .a_i   (r_q.slots[2*k]),
                .b_i   (r_q.slots[2*k+1]),
                .y_o   (tree_y[k])
            );
        end
        for (genvar k = HALF; k < MAXL; k++) begin : g_fill
            assign tree_y[k] = ident_q;
        end
    endgenerate

    // Sequential accumulator step.
    vred_alu u_seq (
        .op_i  (r_q.op),
        .esz_i (r_q.esz),
        .a_i   (r_q.acc),
        .b_i   (r_q.slots[r_q.cnt[LG-1:0]]),
        .y_o   (seq_y)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.op    = op_in;
                    r_d.esz   = esz_i;
                    r_d.tree  = tree_i;
                    r_d.slots = lane_w;
                    r_d.cnt   = '0;
                    r_d.acc   = vred_identity(op_in, esz_i);
                    if (tree_i) begin
                        r_d.state = ST_TREE;
                        r_d.last  = CW'(LG) - CW'(esz_i) - CW'(1);
                    end else begin
                        r_d.state = ST_SEQ;
                        r_d.last  = CW'(MAXL >> esz_i) - CW'(1);
                    end
                end
            end
            ST_SEQ: begin
                r_d.acc = seq_y;
                r_d.cnt = r_q.cnt + CW'(1);
                if (r_q.cnt == r_q.last) begin
                    r_d.result = seq_y;
                    r_d.done   = 1'b1;
                    r_d.state  = ST_IDLE;
                end
            end
            ST_TREE: begin
                r_d.slots = tree_y;
                r_d.cnt   = r_q.cnt + CW'(1);
                if (r_q.cnt == r_q.last) begin
                    r_d.result = tree_y[0];
                    r_d.done   = 1'b1;
                    r_d.state  = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign result_o = r_q.result;
    assign done_o   = r_q.done;
    assign busy_o   = (r_q.state != ST_IDLE);

    // Latency counter used only by the checks below.
    logic [15:0] lat_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  lat_q <= '0;
        else if (!busy_o && start_i)  lat_q <= '0;
        else if (busy_o)              lat_q <= lat_q + 16'd1;
    end

    a_r5_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> lat_q == (r_q.tree ? 16'(LG - int'(r_q.esz)) : 16'(MAXL >> r_q.esz)));

    a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    a_r6_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(result_o) |-> done_o);

    a_r3_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (result_o & ~vred_width_mask(r_q.esz)) == 64'd0);

    a_r7_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i && !(r_q.cnt == r_q.last)) |=>
            (busy_o && $stable(r_q.op) && $stable(r_q.esz) && $stable(r_q.tree)));

    a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);
endmodule

// File: tb/vred_top_bench.sv
`timescale 1ns/1ps
module vred_top_bench;
    localparam int VLEN = 256;
    localparam int MAXL = VLEN / 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [VLEN-1:0]   vec = '0;
    logic [MAXL-1:0]   pred = '0;
    logic [1:0]        esz = '0;
    logic [1:0]        op = '0;
    logic              tree = 1'b0;
    logic [63:0]       result;
    logic              done;
    logic              busy;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    vred_top #(.VLEN(VLEN)) u_vred_top (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vec_i(vec), .pred_i(pred),
        .esz_i(esz), .op_i(op), .tree_i(tree),
        .result_o(result), .done_o(done), .busy_o(busy)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_reduce(input logic [VLEN-1:0] v, input logic [MAXL-1:0] p,
                                               input int ez, input int o);
        int w = 8 << ez;
        int lanes = VLEN / w;
        logic [63:0] m = (ez == 3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
        logic [63:0] acc = (o == 1) ? m : 64'd0;
        logic [63:0] e;
        for (int i = 0; i < lanes; i++) begin
            if (p[i]) begin
                e = 64'(v >> (i * w)) & m;
                case (o)
                    0:       acc = (acc + e) & m;
                    1:       acc = acc & e;
                    2:       acc = acc | e;
                    default: acc = acc ^ e;
                endcase
            end
        end
        return acc;
    endfunction

    // Cycle-by-cycle model: a countdown of the cycles left, compared with busy and done every clock.
    task automatic run(input logic [VLEN-1:0] v, input logic [MAXL-1:0] p, input int ez,
                       input int o, input int tr, input bit poke, input string req);
        logic [63:0] exp = ref_reduce(v, p, ez, o);
        int n = tr ? ($clog2(MAXL) - ez) : (MAXL >> ez);
        @(negedge clk);
        start = 1'b1; vec = v; pred = p; esz = 2'(ez); op = 2'(o); tree = tr[0];
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= n; k++) begin
            chk(busy === 1'b1 && done === 1'b0, {req, " R5 busy"}, {62'd0, busy, done}, 64'd2);
            if (poke && k == 2) begin
                // R7: a second request during the reduction must change nothing.
                start = 1'b1; vec = ~v; pred = ~p; op = 2'(o + 1); esz = 2'(ez ^ 1); tree = ~tr[0];
            end
            if (poke && k == 3) start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        chk(done === 1'b1 && busy === 1'b0, {req, " R5 done"}, {62'd0, busy, done}, 64'd1);
        chk(result === exp, req, result, exp);
        @(negedge clk);
        chk(done === 1'b0 && result === exp, {req, " R6 hold"}, result, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [VLEN-1:0] v;
        logic [MAXL-1:0] p;
        repeat (3) @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0 && result === 64'd0, "R10 reset", result, 64'd0);
        rst_n = 1'b1;

        // R1 R8: {1,2,3,4} in 32-bit lanes gives 10 in both orders.
        v = '0;
        v[31:0] = 32'd1; v[63:32] = 32'd2; v[95:64] = 32'd3; v[127:96] = 32'd4;
        run(v, 32'h0000_000F, 2, 0, 0, 1'b0, "R1 seq 1..4");
        run(v, 32'h0000_000F, 2, 0, 1, 1'b0, "R8 tree 1..4");
        chk(ref_reduce(v, 32'h0000_000F, 2, 0) === 64'd10, "R1 model", ref_reduce(v, 32'h0000_000F, 2, 0), 64'd10);

        // R1: wrap modulo 2^8.
        v = '1;
        run(v, '1, 0, 0, 0, 1'b0, "R1 wrap seq");
        run(v, '1, 0, 0, 1, 1'b0, "R1 wrap tree");

        // R4: all lanes masked, AND gives all ones of the lane width.
        v = '0;
        run(v, '0, 1, 1, 0, 1'b0, "R4 and identity");
        run(v, '0, 1, 1, 1, 1'b0, "R4 and identity tree");

        // R4: predicate bits above the 4 lanes of 64-bit width are ignored.
        v = {64'd7, 64'd5, 64'd3, 64'd1};
        run(v, 32'hFFFF_FFF0, 3, 0, 0, 1'b0, "R4 upper pred");
        run(v, 32'hFFFF_FFF5, 3, 2, 1, 1'b0, "R4 R2 upper pred or");

        // R7: request during busy is ignored.
        for (int w = 0; w < 8; w++) v[w*32 +: 32] = $urandom;
        run(v, 32'hA5A5_3C3C, 0, 0, 0, 1'b1, "R7 ignore seq");
        run(v, 32'h0F0F_F0F0, 1, 3, 0, 1'b1, "R7 ignore xor");

        // R2 R3 R8 R9: sweep widths, operations and orders.
        for (int ez = 0; ez < 4; ez++) begin
            for (int o = 0; o < 4; o++) begin
                for (int w = 0; w < 8; w++) v[w*32 +: 32] = $urandom;
                p = $urandom;
                run(v, p, ez, o, 0, 1'b0, "R2 R3 R9 seq sweep");
                run(v, p, ez, o, 1, 1'b0, "R2 R3 R8 tree sweep");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule